// File: doc/BRIEF.md
# Segment Selector to Linear Address Translator

This block turns a memory reference given as a 16-bit segment selector and a 32-bit offset into a 32-bit linear address. A flag inside the selector chooses one of two descriptor tables, a global one and a local one. Each table has a base and a byte limit, and both are loaded through a small register-write port. The block first checks the selector's index against the chosen table's limit. If the index fits, it reads one 64-bit descriptor from the table through a memory read port with a valid handshake. It then checks the descriptor's present bit, its privilege level and its segment limit, and returns either base plus offset or a 2-bit fault code.

Requests use a valid/ready handshake and only one is in flight at a time. The requester's current privilege level is sampled when a request is accepted. Each result is held on the response port until the consumer accepts it.

Top module: `seg_xlat_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `req_ready` is 1 and both `rsp_valid` and `mem_rd_en` are 0.
- R2: Selector bits [15:3] are the descriptor index, bit 2 picks the table (0 global, 1 local) and bits [1:0] are the requested privilege. The block issues exactly one read pulse per request at address table base + index*8, and no other reads.
- R3: When index*8+7 exceeds the chosen table's limit, the result is fault code 0 and no descriptor read is issued.
- R4: The descriptor is laid out as base [31:0], segment limit [51:32], privilege level [53:52] and present [54]. When present is 0 the result is fault code 1.
- R5: With the effective level defined as the larger of the sampled current level and the selector's requested level, a level numerically above the descriptor level gives fault code 2. Equal levels pass.
- R6: An offset above the 20-bit segment limit (zero-extended) gives fault code 3. An offset equal to the limit passes.
- R7: When several faults apply, the code reported follows the order table bound (0), then not present (1), then privilege (2), then segment limit (3).
- R8: On success, `rsp_fault` is 0 and `rsp_lin_addr` is descriptor base plus offset, modulo 2^32.
- R9: `req_ready` drops after an acceptance and stays low until the response has been taken. While `rsp_valid` is high and `rsp_ready` is low, the response does not change.
- R10: A table write with `tbl_wr_sel` 0 or 1 replaces only the global or only the local base and limit. Later requests use the new values, and a change of `cur_priv` after acceptance has no effect on a request already accepted.
- R11: Whenever `rsp_fault` is 1, `rsp_lin_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table register write strobe |
| tbl_wr_sel | input | 1 | Table to write: 0 global, 1 local |
| tbl_wr_base | input | 32 | New table base address |
| tbl_wr_limit | input | 16 | New table byte limit |
| cur_priv | input | 2 | Current privilege level, sampled on acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_sel | input | 16 | Segment selector |
| req_offset | input | 32 | Offset within the segment |
| mem_rd_en | output | 1 | Descriptor read strobe, one cycle |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_valid | input | 1 | Descriptor read data valid |
| mem_rd_data | input | 64 | Descriptor word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_fault | output | 1 | Request faulted |
| rsp_code | output | 2 | Fault code (0 table, 1 absent, 2 privilege, 3 segment limit) |
| rsp_lin_addr | output | 32 | Linear address (zero on fault) |

## Verification
The bench builds the block with the package defaults: two tables, 32-bit addresses, 16-bit table limits and 20-bit segment limits. Both table limits are programmed small, which puts the last entry that still fits and the first one past each limit within a handful of selectors. The descriptors are chosen so that several faults apply to the same request, which exercises the fault ordering. One descriptor has a base near the top of the address space so that the sum wraps. The response-ready pattern adds back-pressure, so results must stay stable while they wait.

// File: rtl/seg_xlat_pkg.sv
`timescale 1ns/1ps
package seg_xlat_pkg;

    localparam int ADDR_W          = 32;
    localparam int IDX_W           = 13;
    localparam int PRIV_W          = 2;
    localparam int TBL_LIM_W       = 16;
    localparam int SEG_LIM_W       = 20;
    localparam int DESC_W          = 64;
    localparam int DESC_BYTES_LOG2 = 3;
    localparam int NUM_TBL         = 2;
    localparam int TBL_IDX_W       = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;
    localparam int SEL_W           = IDX_W + 1 + PRIV_W;

    // descriptor field positions
    localparam int D_BASE_LSB = 0;
    localparam int D_LIM_LSB  = D_BASE_LSB + ADDR_W;
    localparam int D_DPL_LSB  = D_LIM_LSB + SEG_LIM_W;
    localparam int D_PRES_BIT = D_DPL_LSB + PRIV_W;

    typedef enum logic [1:0] {
        FLT_TABLE  = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PRIV   = 2'd2,
        FLT_SEGLIM = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WAIT,
        ST_RESP
    } xlat_st_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              use_local;
        logic [PRIV_W-1:0] rpl;
    } sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0]    base;
        logic [TBL_LIM_W-1:0] limit;
    } tbl_reg_t;

    typedef struct packed {
        logic [ADDR_W-1:0]    base;
        logic [SEG_LIM_W-1:0] limit;
        logic [PRIV_W-1:0]    dpl;
        logic                 present;
    } desc_t;

    typedef struct packed {
        logic              fault;
        fault_e            code;
        logic [ADDR_W-1:0] lin;
    } xlat_res_t;

    function automatic desc_t unpack_desc(input logic [DESC_W-1:0] w);
        desc_t d;
        d.base    = w[D_BASE_LSB +: ADDR_W];
        d.limit   = w[D_LIM_LSB +: SEG_LIM_W];
        d.dpl     = w[D_DPL_LSB +: PRIV_W];
        d.present = w[D_PRES_BIT];
        return d;
    endfunction

    // numerically larger level is the less privileged one
    function automatic logic [PRIV_W-1:0] weaker_priv(input logic [PRIV_W-1:0] a,
                                                       input logic [PRIV_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_tbl_regs.sv
`timescale 1ns/1ps
module seg_tbl_regs
    import seg_xlat_pkg::*;
#(
    parameter int N_TBL = NUM_TBL,
    localparam int IW   = (N_TBL > 1) ? $clog2(N_TBL) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  tbl_reg_t      wr_val,
    input  logic [IW-1:0] rd_idx,
    output tbl_reg_t      rd_val
);

    tbl_reg_t regs [N_TBL];

    for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                regs[g] <= wr_val;
            end
        end
    end

    assign rd_val = regs[rd_idx];

endmodule

// File: rtl/seg_sel_decode.sv
`timescale 1ns/1ps
module seg_sel_decode
    import seg_xlat_pkg::*;
(
    input  sel_t              sel,
    input  tbl_reg_t          tbl,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              bound_fault
);

    localparam int SPAN_W = IDX_W + DESC_BYTES_LOG2;
    localparam int CMP_W  = ((SPAN_W > TBL_LIM_W) ? SPAN_W : TBL_LIM_W) + 1;

    logic [SPAN_W-1:0] first_byte;
    logic [SPAN_W-1:0] last_byte;

    assign first_byte  = {sel.idx, {DESC_BYTES_LOG2{1'b0}}};
    assign last_byte   = {sel.idx, {DESC_BYTES_LOG2{1'b1}}};
    assign bound_fault = CMP_W'(last_byte) > CMP_W'(tbl.limit);
    assign desc_addr   = tbl.base + ADDR_W'(first_byte);

endmodule

// File: rtl/seg_desc_check.sv
`timescale 1ns/1ps
module seg_desc_check
    import seg_xlat_pkg::*;
(
    input  logic [DESC_W-1:0] desc_word,
    input  logic [ADDR_W-1:0] offset,
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] rpl,
    output xlat_res_t         res
);

    desc_t             d;
    logic [PRIV_W-1:0] eff_priv;
    logic              over_limit;

    assign d          = unpack_desc(desc_word);
    assign eff_priv   = weaker_priv(cpl, rpl);
    assign over_limit = offset > ADDR_W'(d.limit);

    always_comb begin
        res       = '0;
        res.fault = 1'b1;
        if (!d.present) begin
            res.code = FLT_ABSENT;
        end else if (eff_priv > d.dpl) begin
            res.code = FLT_PRIV;
        end else if (over_limit) begin
            res.code = FLT_SEGLIM;
        end else begin
            res.fault = 1'b0;
            res.lin   = d.base + offset;
        end
    end

endmodule

// File: rtl/seg_xlat_unit.sv
`timescale 1ns/1ps
module seg_xlat_unit
    import seg_xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tbl_wr_en,
    input  logic [TBL_IDX_W-1:0] tbl_wr_sel,
    input  logic [ADDR_W-1:0]    tbl_wr_base,
    input  logic [TBL_LIM_W-1:0] tbl_wr_limit,
    input  logic [PRIV_W-1:0]    cur_priv,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SEL_W-1:0]     req_sel,
    input  logic [ADDR_W-1:0]    req_offset,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [DESC_W-1:0]    mem_rd_data,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic                 rsp_fault,
    output logic [1:0]           rsp_code,
    output logic [ADDR_W-1:0]    rsp_lin_addr
);

    xlat_st_e          st_q;
    sel_t              sel_q;
    logic [ADDR_W-1:0] off_q;
    logic [PRIV_W-1:0] cpl_q;
    xlat_res_t         res_q;

    tbl_reg_t          tbl_wr_val;
    tbl_reg_t          tbl_cur;
    logic [ADDR_W-1:0] desc_addr;
    logic              bound_fault;
    xlat_res_t         chk_res;

    assign tbl_wr_val.base  = tbl_wr_base;
    assign tbl_wr_val.limit = tbl_wr_limit;

    seg_tbl_regs #(.N_TBL(NUM_TBL)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_sel),
        .wr_val (tbl_wr_val),
        .rd_idx (TBL_IDX_W'(sel_q.use_local)),
        .rd_val (tbl_cur)
    );

    seg_sel_decode u_dec (
        .sel         (sel_q),
        .tbl         (tbl_cur),
        .desc_addr   (desc_addr),
        .bound_fault (bound_fault)
    );

    seg_desc_check u_chk_desc (
        .desc_word (mem_rd_data),
        .offset    (off_q),
        .cpl       (cpl_q),
        .rpl       (sel_q.rpl),
        .res       (chk_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            sel_q <= '0;
            off_q <= '0;
            cpl_q <= '0;
            res_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        sel_q <= sel_t'(req_sel);
                        off_q <= req_offset;
                        cpl_q <= cur_priv;
                        st_q  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (bound_fault) begin
                        res_q.fault <= 1'b1;
                        res_q.code  <= FLT_TABLE;
                        res_q.lin   <= '0;
                        st_q        <= ST_RESP;
                    end else begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        res_q <= chk_res;
                        st_q  <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st_q == ST_IDLE);
    assign mem_rd_en    = (st_q == ST_LOOKUP) && !bound_fault;
    assign mem_rd_addr  = desc_addr;
    assign rsp_valid    = (st_q == ST_RESP);
    assign rsp_fault    = res_q.fault;
    assign rsp_code     = res_q.code;
    assign rsp_lin_addr = res_q.lin;

endmodule

// File: rtl/seg_xlat_chk.sv
`timescale 1ns/1ps
module seg_xlat_chk
    import seg_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_en,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_fault,
    input logic [1:0]        rsp_code,
    input logic [ADDR_W-1:0] rsp_lin_addr
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_rd_en));

    // R9
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
            && $stable(rsp_code) && $stable(rsp_lin_addr)));

    // R2
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R2
    read_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (!req_ready && !rsp_valid));

    // R11
    fault_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_lin_addr == '0));

endmodule

bind seg_xlat_unit seg_xlat_chk u_xlat_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_rd_en    (mem_rd_en),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_fault    (rsp_fault),
    .rsp_code     (rsp_code),
    .rsp_lin_addr (rsp_lin_addr)
);

// File: tb/tb_seg_xlat_unit.sv
`timescale 1ns/1ps
module tb_seg_xlat_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_wr_en = 1'b0;
    logic [0:0]  tbl_wr_sel = '0;
    logic [31:0] tbl_wr_base = '0;
    logic [15:0] tbl_wr_limit = '0;
    logic [1:0]  cur_priv = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [31:0] req_offset = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_lin_addr;

    always #2.5 clk = ~clk;

    seg_xlat_unit dut (
        .clk          (clk),
        .rst          (rst),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_wr_sel   (tbl_wr_sel),
        .tbl_wr_base  (tbl_wr_base),
        .tbl_wr_limit (tbl_wr_limit),
        .cur_priv     (cur_priv),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_sel      (req_sel),
        .req_offset   (req_offset),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_fault    (rsp_fault),
        .rsp_code     (rsp_code),
        .rsp_lin_addr (rsp_lin_addr)
    );

    typedef struct packed {
        logic        f;
        logic [1:0]  c;
        logic [31:0] a;
        logic        rd;
    } exp_t;

    exp_t        expq[$];
    string       tagq[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          rd_count = 0;
    int          exp_reads = 0;
    logic [63:0] dmem [logic [31:0]];
    logic [31:0] tb_base [2];
    logic [15:0] tb_lim [2];

    // descriptor memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        if (mem_rd_en) begin
            mem_rd_data <= dmem.exists(mem_rd_addr) ? dmem[mem_rd_addr] : 64'h0;
            rd_count    <= rd_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                            input logic [1:0] dpl, input logic pres);
        return {9'b0, pres, dpl, lim, base};
    endfunction

    function automatic exp_t predict(input logic [15:0] sel, input logic [31:0] off,
                                     input logic [1:0] cpl);
        exp_t        e;
        logic [12:0] idx;
        logic        t;
        logic [1:0]  rpl;
        logic [1:0]  eff;
        logic [31:0] a;
        logic [63:0] w;
        idx = sel[15:3];
        t   = sel[2];
        rpl = sel[1:0];
        e   = '0;
        e.f = 1'b1;
        if ({1'b0, idx, 3'b111} > {1'b0, tb_lim[t]}) begin
            e.c = 2'd0;
            return e;
        end
        e.rd = 1'b1;
        a    = tb_base[t] + {16'b0, idx, 3'b000};
        w    = dmem.exists(a) ? dmem[a] : 64'h0;
        eff  = (cpl > rpl) ? cpl : rpl;
        if (!w[54])                        e.c = 2'd1;
        else if (eff > w[53:52])           e.c = 2'd2;
        else if (off > {12'b0, w[51:32]})  e.c = 2'd3;
        else begin
            e.f = 1'b0;
            e.a = w[31:0] + off;
        end
        return e;
    endfunction

    task automatic put_desc(input int t, input int idx, input logic [63:0] d);
        dmem[tb_base[t] + 32'(idx * 8)] = d;
    endtask

    task automatic wr_tbl(input logic t, input logic [31:0] base, input logic [15:0] lim);
        @(negedge clk);
        tbl_wr_en    = 1'b1;
        tbl_wr_sel   = t;
        tbl_wr_base  = base;
        tbl_wr_limit = lim;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        tb_base[t] = base;
        tb_lim[t]  = lim;
    endtask

    task automatic send(input logic [15:0] sel, input logic [31:0] off,
                        input logic [1:0] cpl, input string tag);
        exp_t e;
        e = predict(sel, off, cpl);
        if (e.rd) exp_reads++;
        expq.push_back(e);
        tagq.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_sel    = sel;
        req_offset = off;
        cur_priv   = cpl;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        cur_priv   = ~cpl;
        req_sel    = 16'hFFFF;
        req_offset = 32'hFFFF_FFFF;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor; also drives response back-pressure
    always @(negedge clk) begin
        exp_t  e;
        string tg;
        cyc++;
        rsp_ready = ((cyc % 3) != 1);
        if (!rst && rsp_valid && rsp_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R9", "unexpected response", {29'b0, rsp_fault, rsp_code, rsp_lin_addr}, 64'h0);
            end else begin
                e  = expq.pop_front();
                tg = tagq.pop_front();
                chk((rsp_fault == e.f) && (rsp_code == e.c) && (rsp_lin_addr == e.a), tg,
                    "response {fault,code,addr}",
                    {29'b0, rsp_fault, rsp_code, rsp_lin_addr}, {29'b0, e.f, e.c, e.a});
                chk(!req_ready, "R9", "ready while response pending", {63'b0, req_ready}, 64'h0);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        int snap;
        tb_base[0] = '0; tb_lim[0] = '0;
        tb_base[1] = '0; tb_lim[1] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready in reset", {63'b0, req_ready}, 64'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {63'b0, rsp_valid}, 64'h0);
        chk(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset", {63'b0, mem_rd_en}, 64'h0);
        rst = 1'b0;

        wr_tbl(1'b0, 32'h0000_1000, 16'h003F);
        wr_tbl(1'b1, 32'h0000_8000, 16'h0017);
        put_desc(0, 1, mk_desc(32'h0010_0000, 20'h00FFF, 2'd3, 1'b1));
        put_desc(0, 2, mk_desc(32'hFFFF_F000, 20'hFFFFF, 2'd0, 1'b1));
        put_desc(0, 3, mk_desc(32'h0000_5000, 20'h00000, 2'd0, 1'b0));
        put_desc(0, 4, mk_desc(32'h0003_0000, 20'h00010, 2'd1, 1'b1));
        put_desc(1, 0, mk_desc(32'h2000_0000, 20'h00100, 2'd2, 1'b1));
        put_desc(1, 1, mk_desc(32'h4000_0000, 20'h0FFFF, 2'd3, 1'b1));

        send(16'h0008, 32'h0000_0123, 2'd0, "R8 global base plus offset");
        send(16'h000C, 32'h0000_0040, 2'd3, "R2 local table selected");
        send(16'h0004, 32'h0000_0100, 2'd2, "R6 offset equal to limit");
        send(16'h0004, 32'h0000_0101, 2'd2, "R6 R11 offset past limit");
        send(16'h0010, 32'h0000_1800, 2'd0, "R8 address wraps");
        drain();

        snap = rd_count;
        send(16'h0040, 32'h0, 2'd0, "R3 index past global limit");
        send(16'h001C, 32'h0, 2'd0, "R3 index past local limit");
        drain();
        chk(rd_count == snap, "R3", "reads on bound fault", 64'(rd_count), 64'(snap));

        send(16'h0038, 32'h0, 2'd0, "R4 last fitting entry absent");
        send(16'h0018, 32'h0, 2'd3, "R7 absent before privilege");
        send(16'h0022, 32'h0, 2'd0, "R5 requested level raises");
        send(16'h0020, 32'h0000_0011, 2'd1, "R7 limit fault when level ok");
        send(16'h0020, 32'h0000_0011, 2'd2, "R7 privilege before limit");
        send(16'h0021, 32'h0000_0010, 2'd1, "R5 equal level passes");
        send(16'h0020, 32'h0000_0004, 2'd0, "R10 level sampled on accept");
        drain();

        wr_tbl(1'b0, 32'h0000_1000, 16'h0007);
        send(16'h0008, 32'h0, 2'd0, "R10 shrunk global limit");
        send(16'h0000, 32'h0, 2'd0, "R10 entry zero still fits");
        send(16'h0004, 32'h0000_0010, 2'd0, "R10 local table untouched");
        drain();

        chk(rd_count == exp_reads, "R2", "descriptor read count", 64'(rd_count), 64'(exp_reads));
        finish_run();
    end

endmodule